// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller with Context Stacks

This block sits beside a small processor sequencer and decides when and where an interrupt is taken. Each request line can be set to edge mode, where a rising edge is caught and held, or to level mode, where the line itself is the request. The effective requests are gated by a mask register. The lowest-numbered enabled request wins. A request is acted on only when the sequencer signals an instruction boundary, so a request that arrives in the middle of an instruction waits for that boundary.

When a request is accepted, the block pushes the return address onto a PC stack. In the same cycle it pushes one status record onto a status stack. The record holds the arithmetic status word, the mode status word and the current mask, packed in that order with the arithmetic word in the most significant field. The mask is then reloaded with a nesting-control value supplied at an input. On the next cycle the block raises a one-cycle vector strobe, which is the no-operation slot while the vector is fetched, together with the vector address. A return strobe pops both stacks. The block then presents the saved address and status words and restores the saved mask. Both stacks are four entries deep. Pushing onto a full stack or popping an empty one is refused and sets a sticky flag.

Reset is the non-maskable event: it clears every latch, the mask, both stacks and both flags.

Top module: `intc_ctx`

## Requirements
- R1: A request is accepted only in a cycle with `insn_done` high. `vec_valid` rises in the cycle after that boundary and stays low while no boundary occurs.
- R2: A line whose `mask_q` bit is 0 is never accepted. An edge capture on a masked line is kept and is taken at a later boundary once the bit is set.
- R3: When several enabled requests are present, the lowest line index is accepted first. The others stay pending.
- R4: With `edge_sel[i]`=1, a rising edge on `irq_req[i]` is held until that line is accepted and is then cleared. With `edge_sel[i]`=0, the line is requested only if `irq_req[i]` is high at the boundary.
- R5: `vec_addr` = VEC_BASE + (index << 2), with a default VEC_BASE of 0x040. `vec_valid` is high for exactly one cycle per acceptance.
- R6: On acceptance, `mask_q` takes the value of `nest_mask` and is visible in the `vec_valid` cycle.
- R7: `ret_strobe` makes `ret_valid` pulse one cycle later. At that point `ret_pc`, `ret_astat` and `ret_mstat` equal the values pushed by the most recent unreturned entry, in last-in-first-out order, and `mask_q` returns to the mask saved by that entry. A return strobe in the `vec_valid` cycle is ignored.
- R8: An acceptance attempt with 4 entries already stacked pushes nothing and produces no `vec_valid`. It sets `stk_ovf`, which stays set until reset.
- R9: A return strobe with both stacks empty produces no `ret_valid` and sets `stk_unf`, which stays set until reset.
- R10: After reset, `vec_valid`, `ret_valid`, `mask_q`, `stk_ovf` and `stk_unf` are all 0.
- R11: A `mask_wr` pulse loads `mask_wdata` into `mask_q` one cycle later, unless an entry or a return in the same cycle sets the mask.
- R12: If `ret_strobe` and `insn_done` are high in the same cycle, the return is carried out and no entry occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, non-maskable |
| irq_req | input | N_LINES | Request lines, index 0 highest priority |
| edge_sel | input | N_LINES | Per-line mode: 1 edge, 0 level |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | N_LINES | Mask write value |
| nest_mask | input | N_LINES | Mask loaded on entry (nesting control) |
| insn_done | input | 1 | Instruction boundary strobe |
| ret_strobe | input | 1 | Return-from-interrupt strobe |
| next_pc | input | PC_W | Address of the next instruction |
| astat | input | ST_W | Arithmetic status word |
| mstat | input | ST_W | Mode status word |
| vec_valid | output | 1 | Entry no-operation cycle, vector valid |
| vec_addr | output | PC_W | Vector address |
| ret_valid | output | 1 | Return data valid |
| ret_pc | output | PC_W | Popped return address |
| ret_astat | output | ST_W | Popped arithmetic status |
| ret_mstat | output | ST_W | Popped mode status |
| mask_q | output | N_LINES | Current mask register |
| stk_ovf | output | 1 | Sticky stack overflow flag |
| stk_unf | output | 1 | Sticky stack underflow flag |

## Verification
An edge is caught at the clock edge where the line is first seen high. It can therefore be accepted no earlier than the following boundary, and `vec_valid`, `vec_addr` and the reloaded `mask_q` all appear one cycle after the accepting `insn_done`. The return outputs and the restored mask appear one cycle after `ret_strobe`. The overflow and underflow flags are sampled one cycle after the refused attempt. The bench changes inputs one time unit after a rising edge and samples outputs one time unit after the next rising edge. It leaves an idle cycle after every entry, because a return strobe in the vector cycle is ignored.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [1:0] {
    STK_IDLE = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2
  } stk_op_e;
endpackage

// File: rtl/intc_req_latch.sv
module intc_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic edge_mode,
  input  logic clr,
  output logic eff
);
  logic prev_q;
  logic lat_q;
  logic rise;

  assign rise = req & ~prev_q;
  assign eff  = edge_mode ? lat_q : req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      lat_q  <= 1'b0;
    end else begin
      prev_q <= req;
      if (!edge_mode) lat_q <= 1'b0;
      else            lat_q <= (lat_q & ~clr) | rise;
    end
  end

  // R4: a held edge survives until it is accepted
  p_edge_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && lat_q && !clr) |=> lat_q);
endmodule

// File: rtl/intc_pick.sv
module intc_pick #(
  parameter int unsigned N  = 4,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  elig,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  grant
);
  function automatic logic [IW-1:0] lowest_set(input logic [N-1:0] v);
    lowest_set = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) lowest_set = IW'(i);
    end
  endfunction

  assign any   = |elig;
  assign idx   = lowest_set(elig);
  assign grant = any ? (N'(1) << idx) : '0;

  // R3: the chosen line is eligible and nothing lower is
  always_comb begin
    if (any) begin
      a_pick_lowest_r3: assert (elig[idx] && ((elig & ((N'(1) << idx) - N'(1))) == '0));
    end
  end
endmodule

// File: rtl/intc_lifo.sv
module intc_lifo
  import intc_pkg::*;
#(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  stk_op_e      op,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] count_q;

  assign full  = (count_q == CW'(DEPTH));
  assign empty = (count_q == '0);
  assign dout  = mem[AW'(count_q - CW'(1))];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else begin
      if (op == STK_PUSH)     count_q <= count_q + CW'(1);
      else if (op == STK_POP) count_q <= count_q - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (op == STK_PUSH) mem[AW'(count_q)] <= din;
  end

  // R8: the controller never pushes onto a full stack
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == STK_PUSH) |-> !full);
  // R9: the controller never pops an empty stack
  p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == STK_POP) |-> !empty);
endmodule

// File: rtl/intc_ctx.sv
module intc_ctx
  import intc_pkg::*;
#(
  parameter int unsigned N_LINES  = 4,
  parameter int unsigned PC_W     = 14,
  parameter int unsigned ST_W     = 16,
  parameter int unsigned DEPTH    = 4,
  parameter int unsigned VEC_BASE = 32'h40,
  localparam int unsigned IW = (N_LINES > 1) ? $clog2(N_LINES) : 1,
  localparam int unsigned SW = 2 * ST_W + N_LINES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_req,
  input  logic [N_LINES-1:0] edge_sel,
  input  logic               mask_wr,
  input  logic [N_LINES-1:0] mask_wdata,
  input  logic [N_LINES-1:0] nest_mask,
  input  logic               insn_done,
  input  logic               ret_strobe,
  input  logic [PC_W-1:0]    next_pc,
  input  logic [ST_W-1:0]    astat,
  input  logic [ST_W-1:0]    mstat,
  output logic               vec_valid,
  output logic [PC_W-1:0]    vec_addr,
  output logic               ret_valid,
  output logic [PC_W-1:0]    ret_pc,
  output logic [ST_W-1:0]    ret_astat,
  output logic [ST_W-1:0]    ret_mstat,
  output logic [N_LINES-1:0] mask_q,
  output logic               stk_ovf,
  output logic               stk_unf
);
  function automatic logic [PC_W-1:0] vec_of(input logic [IW-1:0] i);
    vec_of = PC_W'(VEC_BASE) + (PC_W'(i) << 2);
  endfunction

  logic [N_LINES-1:0] eff_req;
  logic [N_LINES-1:0] elig;
  logic [N_LINES-1:0] grant;
  logic [N_LINES-1:0] clr_vec;
  logic               any_elig;
  logic [IW-1:0]      win_idx;
  logic [IW-1:0]      vec_idx_q;

  // named internal events
  logic do_ret, try_acc, accept, pop_ok;
  logic pc_full, pc_empty, st_full, st_empty;
  stk_op_e            stk_op;
  logic [PC_W-1:0]    pc_dout;
  logic [SW-1:0]      st_din, st_dout;

  genvar g;
  generate
    for (g = 0; g < N_LINES; g++) begin : g_line
      intc_req_latch u_lat (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (irq_req[g]),
        .edge_mode (edge_sel[g]),
        .clr       (clr_vec[g]),
        .eff       (eff_req[g])
      );
    end
  endgenerate

  assign elig = eff_req & mask_q;

  intc_pick #(.N(N_LINES)) u_pick (
    .elig  (elig),
    .any   (any_elig),
    .idx   (win_idx),
    .grant (grant)
  );

  assign do_ret  = ret_strobe & ~vec_valid;
  assign try_acc = insn_done & any_elig & ~do_ret & ~vec_valid;
  assign accept  = try_acc & ~pc_full;
  assign pop_ok  = do_ret & ~pc_empty;
  assign clr_vec = accept ? grant : '0;
  assign stk_op  = accept ? STK_PUSH : (pop_ok ? STK_POP : STK_IDLE);
  assign st_din  = {astat, mstat, mask_q};

  intc_lifo #(.W(PC_W), .DEPTH(DEPTH)) u_pc_stk (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (stk_op),
    .din   (next_pc),
    .dout  (pc_dout),
    .full  (pc_full),
    .empty (pc_empty)
  );

  intc_lifo #(.W(SW), .DEPTH(DEPTH)) u_st_stk (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (stk_op),
    .din   (st_din),
    .dout  (st_dout),
    .full  (st_full),
    .empty (st_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec_addr  <= '0;
      vec_idx_q <= '0;
      ret_valid <= 1'b0;
      ret_pc    <= '0;
      ret_astat <= '0;
      ret_mstat <= '0;
      mask_q    <= '0;
      stk_ovf   <= 1'b0;
      stk_unf   <= 1'b0;
    end else begin
      vec_valid <= accept;
      ret_valid <= pop_ok;
      if (accept) begin
        vec_addr  <= vec_of(win_idx);
        vec_idx_q <= win_idx;
      end
      if (pop_ok) begin
        ret_pc    <= pc_dout;
        ret_astat <= st_dout[SW-1 -: ST_W];
        ret_mstat <= st_dout[N_LINES +: ST_W];
      end
      if (accept)       mask_q <= nest_mask;
      else if (pop_ok)  mask_q <= st_dout[N_LINES-1:0];
      else if (mask_wr) mask_q <= mask_wdata;
      if (try_acc && pc_full) stk_ovf <= 1'b1;
      if (do_ret && pc_empty) stk_unf <= 1'b1;
    end
  end

  // R1: an entry follows a boundary
  p_vec_boundary_r1: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(insn_done));
  // R2: the accepted line was enabled in the mask
  p_vec_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> ((($past(mask_q) >> vec_idx_q) & N_LINES'(1)) != '0));
  // R5: single no-operation slot
  p_vec_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid);
  // R6: the nesting value is in the mask during the vector cycle
  p_mask_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (mask_q == $past(nest_mask)));
  // R7: return data follows a return strobe
  p_ret_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> $past(ret_strobe));
  // R8: both stacks move in step
  p_stk_lockstep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_full == st_full) && (pc_empty == st_empty));
  // R12: no entry and return together
  p_ret_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(vec_valid && ret_valid));
endmodule

// File: tb/intc_ctx_bench.sv
module intc_ctx_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  irq_req, edge_sel, mask_wdata, nest_mask;
  logic        mask_wr, insn_done, ret_strobe;
  logic [13:0] next_pc;
  logic [15:0] astat, mstat;
  logic        vec_valid, ret_valid, stk_ovf, stk_unf;
  logic [13:0] vec_addr, ret_pc;
  logic [15:0] ret_astat, ret_mstat;
  logic [3:0]  mask_q;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  intc_ctx u_intc_ctx (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .edge_sel(edge_sel),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata), .nest_mask(nest_mask),
    .insn_done(insn_done), .ret_strobe(ret_strobe), .next_pc(next_pc),
    .astat(astat), .mstat(mstat), .vec_valid(vec_valid), .vec_addr(vec_addr),
    .ret_valid(ret_valid), .ret_pc(ret_pc), .ret_astat(ret_astat),
    .ret_mstat(ret_mstat), .mask_q(mask_q), .stk_ovf(stk_ovf), .stk_unf(stk_unf)
  );

  function automatic logic [13:0] exp_vec(input int i);
    return 14'h040 + 14'(i * 4);
  endfunction

  function automatic int first_one(input logic [3:0] v);
    for (int i = 0; i < 4; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // captured results of an entry attempt and of a return
  logic        c_vv, c_rv;
  logic [13:0] c_va;
  logic [3:0]  c_mask;

  task automatic boundary();
    insn_done = 1'b1; step(); insn_done = 1'b0;
    c_vv = vec_valid; c_va = vec_addr; c_mask = mask_q;
    step();
  endtask

  task automatic do_ret();
    ret_strobe = 1'b1; step(); ret_strobe = 1'b0;
    c_rv = ret_valid; c_mask = mask_q;
  endtask

  task automatic wr_mask(input logic [3:0] m);
    mask_wr = 1'b1; mask_wdata = m; step(); mask_wr = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] p);
    irq_req = p; step(); irq_req = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; irq_req = '0; edge_sel = 4'hF; mask_wr = 0; mask_wdata = 0;
    nest_mask = 0; insn_done = 0; ret_strobe = 0; next_pc = 0; astat = 0; mstat = 0;
    step(); step(); rst_n = 1'b1; step();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [3:0] mlat, m, p, nm;
    logic [13:0] pc;
    logic [15:0] a, s;
    int w;
    void'($urandom(32'd2024));
    do_reset();
    chk("R10 vec_valid", vec_valid, 0);
    chk("R10 ret_valid", ret_valid, 0);
    chk("R10 mask_q", mask_q, 0);
    chk("R10 flags", {stk_ovf, stk_unf}, 0);

    // random edge-mode traffic against a bench model
    mlat = '0;
    for (int it = 0; it < 60; it++) begin
      m = 4'($urandom()); p = 4'($urandom()); nm = 4'($urandom());
      pc = 14'($urandom()); a = 16'($urandom()); s = 16'($urandom());
      wr_mask(m);
      chk("R11 mask write", mask_q, m);
      pulse(p);
      mlat = mlat | p;
      next_pc = pc; astat = a; mstat = s; nest_mask = nm;
      boundary();
      w = first_one(mlat & m);
      if (w < 0) begin
        chk("R2 masked no entry", c_vv, 0);
      end else begin
        mlat[w] = 1'b0;
        chk("R3 R5 entry", c_vv, 1);
        chk("R5 vector", c_va, exp_vec(w));
        chk("R6 nest mask", c_mask, nm);
        do_ret();
        chk("R7 ret_valid", c_rv, 1);
        chk("R7 ret_pc", ret_pc, pc);
        chk("R7 ret_astat", ret_astat, a);
        chk("R7 ret_mstat", ret_mstat, s);
        chk("R7 mask restore", c_mask, m);
        step();
      end
    end

    // directed: masked edge kept, taken after unmask
    do_reset();
    pulse(4'b0010);
    boundary();
    chk("R2 masked edge ignored", c_vv, 0);
    wr_mask(4'b0010);
    next_pc = 14'h123; nest_mask = 4'b0000;
    insn_done = 1; step(); insn_done = 0;
    chk("R2 unmasked entry", vec_valid, 1);
    chk("R5 vector line1", vec_addr, 14'h044);
    chk("R6 nest mask", mask_q, 0);
    step();
    chk("R5 single cycle", vec_valid, 0);
    do_ret();
    chk("R7 ret_pc", ret_pc, 14'h123);
    chk("R7 mask restore", c_mask, 4'b0010);
    step();

    // directed: boundary needed
    wr_mask(4'b1111); nest_mask = 4'b1111;
    pulse(4'b0100);
    step();
    chk("R1 no boundary", vec_valid, 0);
    step();
    chk("R1 no boundary later", vec_valid, 0);
    boundary();
    chk("R1 boundary entry", c_vv, 1);
    chk("R1 vector line2", c_va, 14'h048);
    do_ret(); step();

    // directed: priority and latch clearing
    pulse(4'b1010);
    boundary();
    chk("R3 lower index first", c_va, 14'h044);
    do_ret(); step();
    boundary();
    chk("R3 other pending", c_vv, 1);
    chk("R3 line3 vector", c_va, 14'h04C);
    do_ret(); step();
    boundary();
    chk("R4 latches cleared", c_vv, 0);

    // directed: level mode
    edge_sel = 4'b0111;
    irq_req = 4'b1000; step(); step();
    irq_req = 4'b0000;
    boundary();
    chk("R4 level low at boundary", c_vv, 0);
    irq_req = 4'b1000;
    boundary();
    chk("R4 level entry", c_vv, 1);
    chk("R4 level vector", c_va, 14'h04C);
    ret_strobe = 1; insn_done = 1; step(); ret_strobe = 0; insn_done = 0;
    chk("R12 return done", ret_valid, 1);
    chk("R12 no entry", vec_valid, 0);
    irq_req = 0; step();

    // directed: overflow and underflow
    do_reset();
    edge_sel = 4'b0000; nest_mask = 4'b1111;
    wr_mask(4'b1111);
    irq_req = 4'b0001;
    for (int k = 0; k < 4; k++) begin
      next_pc = 14'(100 + k); astat = 16'(16 + k); mstat = 16'(32 + k);
      boundary();
      chk("R8 entry below depth", c_vv, 1);
    end
    chk("R8 no flag yet", stk_ovf, 0);
    boundary();
    chk("R8 full refused", c_vv, 0);
    chk("R8 overflow flag", stk_ovf, 1);
    irq_req = 0;
    for (int k = 3; k >= 0; k--) begin
      do_ret();
      chk("R7 lifo pc", ret_pc, 14'(100 + k));
      chk("R7 lifo astat", ret_astat, 16'(16 + k));
      chk("R7 lifo mstat", ret_mstat, 16'(32 + k));
    end
    chk("R9 no flag yet", stk_unf, 0);
    do_ret(); step();
    chk("R9 empty no ret", c_rv, 0);
    chk("R9 underflow flag", stk_unf, 1);
    chk("R8 overflow sticky", stk_ovf, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule